// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between a local write bus and a serial link port. Local writes that fall inside a fixed outbound window are sent onto the link at an address taken from a table of translation regions. The region is selected by the upper bits of the offset into the window. The low offset inside the region is kept unchanged. Each region has its own link-side base and enable bit, and one global enable gates the whole outbound path. A write that hits the window while translation is not allowed is dropped and raises a sticky error flag.

Software can retarget a region at run time. A typical sequence points region 0 at a peer's interrupt register, issues one write, and then points it back at the data buffer. Retargeting never changes a write that has already been accepted.

On the inbound side, a link address whose upper bits match a programmable base register is redirected to a fixed local register block, keeping the offset below the register size. All other inbound addresses leave unchanged on a default port. Both paths have one register stage.

Top module: `addr_window_xlat`

## Requirements
- R1: A write accepted with `ob_valid_i` high, whose address has upper bits [31:23] equal to those of the window base 0x6000_0000, uses offset bits [22:20] as the region index r. If it is translated, it appears on the next cycle with `ob_valid_o` high, `ob_addr_o` equal to the base of region r (bits [31:20]) with the address bits [19:0] appended, and `ob_data_o` equal to the write data. Example: region base 0x7000_0000 turns 0x6000_0054 into 0x7000_0054.
- R2: While the global enable is clear, no window write is emitted and each such write sets `err_o`.
- R3: A window write to a region whose enable bit is clear is dropped and sets `err_o`. Regions that are enabled keep translating.
- R4: If a region base is programmed in the same cycle as a window write to that region, the write uses the old base. Writes in later cycles use the new base.
- R5: An inbound address whose bits [31:14] equal the programmed BAR base bits is emitted one cycle later on `reg_valid_o`, at address 0x2180_0000 plus the address bits [13:0], with its data.
- R6: An inbound address that does not match is emitted one cycle later on `pass_valid_o`, with its address and data unchanged.
- R7: `err_o` stays set until a clear command. A fault in the same cycle as a clear leaves it set.
- R8: A local write outside the window is neither emitted nor flagged.
- R9: After reset the following hold:
  - all output valids and `err_o` are low;
  - the global enable and all region enables are clear;
  - all region bases and the BAR base are zero, so inbound 0x0000_0040 is redirected to 0x2180_0040.
- R10: A configuration write (`cfg_we_i` high) acts on the next cycle, with the target chosen by `cfg_sel_i`:
  - 0 selects the region given by `cfg_idx_i`: base from data bits [31:20], enable from bit 0;
  - 1 sets the global enable from bit 0;
  - 2 sets the BAR base from bits [31:14];
  - 3 clears `err_o`.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Configuration target select |
| cfg_idx_i | input | 3 | Region index for region writes |
| cfg_wdata_i | input | 32 | Configuration write data |
| ob_valid_i | input | 1 | Local write valid |
| ob_addr_i | input | 32 | Local write address |
| ob_data_i | input | 32 | Local write data |
| ob_valid_o | output | 1 | Link write valid |
| ob_addr_o | output | 32 | Translated link address |
| ob_data_o | output | 32 | Link write data |
| err_o | output | 1 | Sticky dropped-write flag |
| ib_valid_i | input | 1 | Inbound access valid |
| ib_addr_i | input | 32 | Inbound link address |
| ib_data_i | input | 32 | Inbound data |
| reg_valid_o | output | 1 | Redirected access valid |
| reg_addr_o | output | 32 | Local register block address |
| reg_data_o | output | 32 | Redirected data |
| pass_valid_o | output | 1 | Default-port access valid |
| pass_addr_o | output | 32 | Untranslated address |
| pass_data_o | output | 32 | Default-port data |

## Verification
Some properties are checked on every cycle:
- the kept offset on both translation paths;
- global gating of outbound writes;
- the stickiness and cause of the error flag;
- the effect of a global enable write.

Other behaviour only the bench scenarios can show:
- the full link address for each region across boundary offsets;
- dropped writes to a disabled region;
- which base wins when a reprogram and a write share a cycle;
- the exact match edges of the BAR window.

// File: rtl/addr_window_xlat_pkg.sv
package addr_window_xlat_pkg;
  typedef enum logic [1:0] {
    CFG_REGION  = 2'd0,
    CFG_GLOBAL  = 2'd1,
    CFG_BAR     = 2'd2,
    CFG_ERR_CLR = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/awx_region_table.sv
module awx_region_table
  import addr_window_xlat_pkg::*;
#(
  parameter int AW = 32,
  parameter int NR = 8,
  parameter int RL = 20,
  parameter int BL = 14,
  localparam int IW = $clog2(NR)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  cfg_sel_e                   cfg_sel_i,
  input  logic [IW-1:0]              cfg_idx_i,
  input  logic [AW-1:0]              cfg_wdata_i,
  output logic                       glb_en_o,
  output logic [NR-1:0]              reg_en_o,
  output logic [NR-1:0][AW-RL-1:0]   reg_base_o,
  output logic [AW-BL-1:0]           bar_base_o,
  output logic                       err_clr_o
);
  logic unused_wdata;
  assign unused_wdata = ^cfg_wdata_i;

  for (genvar g = 0; g < NR; g++) begin : g_region
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        reg_base_o[g] <= '0;
        reg_en_o[g]   <= 1'b0;
      end else if (cfg_we_i && cfg_sel_i == CFG_REGION && cfg_idx_i == IW'(g)) begin
        reg_base_o[g] <= cfg_wdata_i[AW-1:RL];
        reg_en_o[g]   <= cfg_wdata_i[0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_en_o   <= 1'b0;
      bar_base_o <= '0;
    end else if (cfg_we_i) begin
      if (cfg_sel_i == CFG_GLOBAL) glb_en_o   <= cfg_wdata_i[0];
      if (cfg_sel_i == CFG_BAR)    bar_base_o <= cfg_wdata_i[AW-1:BL];
    end
  end

  assign err_clr_o = cfg_we_i && (cfg_sel_i == CFG_ERR_CLR);

  assert_glb_prog_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_sel_i == CFG_GLOBAL) |=> (glb_en_o == $past(cfg_wdata_i[0])));
endmodule

// File: rtl/awx_outbound.sv
module awx_outbound #(
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter int          NR       = 8,
  parameter int          RL       = 20,
  parameter logic [31:0] WIN_BASE = 32'h6000_0000,
  localparam int         IW       = $clog2(NR),
  localparam int         WL       = RL + IW
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     glb_en_i,
  input  logic [NR-1:0]            reg_en_i,
  input  logic [NR-1:0][AW-RL-1:0] reg_base_i,
  input  logic                     err_clr_i,
  input  logic                     ob_valid_i,
  input  logic [AW-1:0]            ob_addr_i,
  input  logic [DW-1:0]            ob_data_i,
  output logic                     ob_valid_o,
  output logic [AW-1:0]            ob_addr_o,
  output logic [DW-1:0]            ob_data_o,
  output logic                     err_o
);
  logic          in_win, allow, fault;
  logic [IW-1:0] idx;

  always_comb begin
    in_win = ob_valid_i && (ob_addr_i[AW-1:WL] == WIN_BASE[AW-1:WL]);
    idx    = ob_addr_i[WL-1:RL];
    allow  = glb_en_i && reg_en_i[idx];
    fault  = in_win && !allow;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ob_valid_o <= 1'b0;
      ob_addr_o  <= '0;
      ob_data_o  <= '0;
    end else begin
      ob_valid_o <= in_win && allow;
      if (in_win && allow) begin
        ob_addr_o <= {reg_base_i[idx], ob_addr_i[RL-1:0]};
        ob_data_o <= ob_data_i;
      end
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_o <= 1'b0;
    else if (fault)     err_o <= 1'b1;
    else if (err_clr_i) err_o <= 1'b0;
  end

  assert_offset_keep_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ob_valid_o |-> ob_addr_o[RL-1:0] == $past(ob_addr_i[RL-1:0]));
  assert_glb_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> !ob_valid_o);
  assert_err_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(ob_valid_i));
  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);
endmodule

// File: rtl/awx_inbound.sv
module awx_inbound #(
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter int          BL       = 14,
  parameter logic [31:0] REG_BASE = 32'h2180_0000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-BL-1:0] bar_base_i,
  input  logic             ib_valid_i,
  input  logic [AW-1:0]    ib_addr_i,
  input  logic [DW-1:0]    ib_data_i,
  output logic             reg_valid_o,
  output logic [AW-1:0]    reg_addr_o,
  output logic [DW-1:0]    reg_data_o,
  output logic             pass_valid_o,
  output logic [AW-1:0]    pass_addr_o,
  output logic [DW-1:0]    pass_data_o
);
  logic hit;
  assign hit = ib_addr_i[AW-1:BL] == bar_base_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_valid_o  <= 1'b0;
      reg_addr_o   <= '0;
      reg_data_o   <= '0;
      pass_valid_o <= 1'b0;
      pass_addr_o  <= '0;
      pass_data_o  <= '0;
    end else begin
      reg_valid_o  <= ib_valid_i && hit;
      pass_valid_o <= ib_valid_i && !hit;
      if (ib_valid_i && hit) begin
        reg_addr_o <= {REG_BASE[AW-1:BL], ib_addr_i[BL-1:0]};
        reg_data_o <= ib_data_i;
      end
      if (ib_valid_i && !hit) begin
        pass_addr_o <= ib_addr_i;
        pass_data_o <= ib_data_i;
      end
    end
  end

  assert_ib_offset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_valid_o |-> reg_addr_o[BL-1:0] == $past(ib_addr_i[BL-1:0]));
  assert_ib_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_valid_o |-> pass_addr_o == $past(ib_addr_i));
  assert_ib_cause_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_valid_o || pass_valid_o) |-> $past(ib_valid_i));
endmodule

// File: rtl/addr_window_xlat.sv
module addr_window_xlat
  import addr_window_xlat_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter int          NR       = 8,
  parameter int          RL       = 20,
  parameter int          BL       = 14,
  parameter logic [31:0] WIN_BASE = 32'h6000_0000,
  parameter logic [31:0] REG_BASE = 32'h2180_0000,
  localparam int         IW       = $clog2(NR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [IW-1:0] cfg_idx_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          ob_valid_i,
  input  logic [AW-1:0] ob_addr_i,
  input  logic [DW-1:0] ob_data_i,
  output logic          ob_valid_o,
  output logic [AW-1:0] ob_addr_o,
  output logic [DW-1:0] ob_data_o,
  output logic          err_o,
  input  logic          ib_valid_i,
  input  logic [AW-1:0] ib_addr_i,
  input  logic [DW-1:0] ib_data_i,
  output logic          reg_valid_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_data_o,
  output logic          pass_valid_o,
  output logic [AW-1:0] pass_addr_o,
  output logic [DW-1:0] pass_data_o
);
  logic                     glb_en, err_clr;
  logic [NR-1:0]            reg_en;
  logic [NR-1:0][AW-RL-1:0] reg_base;
  logic [AW-BL-1:0]         bar_base;

  awx_region_table #(.AW(AW), .NR(NR), .RL(RL), .BL(BL)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_e'(cfg_sel_i)),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_wdata_i (cfg_wdata_i),
    .glb_en_o    (glb_en),
    .reg_en_o    (reg_en),
    .reg_base_o  (reg_base),
    .bar_base_o  (bar_base),
    .err_clr_o   (err_clr)
  );

  awx_outbound #(.AW(AW), .DW(DW), .NR(NR), .RL(RL), .WIN_BASE(WIN_BASE)) u_ob (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .glb_en_i   (glb_en),
    .reg_en_i   (reg_en),
    .reg_base_i (reg_base),
    .err_clr_i  (err_clr),
    .ob_valid_i (ob_valid_i),
    .ob_addr_i  (ob_addr_i),
    .ob_data_i  (ob_data_i),
    .ob_valid_o (ob_valid_o),
    .ob_addr_o  (ob_addr_o),
    .ob_data_o  (ob_data_o),
    .err_o      (err_o)
  );

  awx_inbound #(.AW(AW), .DW(DW), .BL(BL), .REG_BASE(REG_BASE)) u_ib (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bar_base_i   (bar_base),
    .ib_valid_i   (ib_valid_i),
    .ib_addr_i    (ib_addr_i),
    .ib_data_i    (ib_data_i),
    .reg_valid_o  (reg_valid_o),
    .reg_addr_o   (reg_addr_o),
    .reg_data_o   (reg_data_o),
    .pass_valid_o (pass_valid_o),
    .pass_addr_o  (pass_addr_o),
    .pass_data_o  (pass_data_o)
  );
endmodule

// File: tb/addr_window_xlat_bench.sv
module addr_window_xlat_bench;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ob_valid = 1'b0;
  logic [31:0] ob_addr = '0, ob_data = '0;
  logic        ob_valid_o, err_o, reg_valid_o, pass_valid_o;
  logic [31:0] ob_addr_o, ob_data_o, reg_addr_o, reg_data_o, pass_addr_o, pass_data_o;
  logic        ib_valid = 1'b0;
  logic [31:0] ib_addr = '0, ib_data = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_base [8];
  bit          m_en   [8];

  always #2.5 clk = ~clk;

  addr_window_xlat u_addr_window_xlat (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_idx_i(cfg_idx), .cfg_wdata_i(cfg_wdata),
    .ob_valid_i(ob_valid), .ob_addr_i(ob_addr), .ob_data_i(ob_data),
    .ob_valid_o(ob_valid_o), .ob_addr_o(ob_addr_o), .ob_data_o(ob_data_o), .err_o(err_o),
    .ib_valid_i(ib_valid), .ib_addr_i(ib_addr), .ib_data_i(ib_data),
    .reg_valid_o(reg_valid_o), .reg_addr_o(reg_addr_o), .reg_data_o(reg_data_o),
    .pass_valid_o(pass_valid_o), .pass_addr_o(pass_addr_o), .pass_data_o(pass_data_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [1:0] sel, input logic [2:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ob_send(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    ob_valid = 1'b1; ob_addr = a; ob_data = d;
    @(negedge clk);
    ob_valid = 1'b0;
  endtask

  task automatic ib_send(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    ib_valid = 1'b1; ib_addr = a; ib_data = d;
    @(negedge clk);
    ib_valid = 1'b0;
  endtask

  task automatic clear_err();
    cfg_wr(2'd3, 3'd0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] offs [3];
    offs[0] = 32'h0; offs[1] = 32'h54; offs[2] = 32'hF_FFFC;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 ob_valid", {31'd0, ob_valid_o}, 32'd0);
    chk("R9 err", {31'd0, err_o}, 32'd0);
    chk("R9 reg_valid", {31'd0, reg_valid_o}, 32'd0);
    chk("R9 pass_valid", {31'd0, pass_valid_o}, 32'd0);
    ib_send(32'h0000_0040, 32'hAAAA_0001);
    chk("R9 bar reset redirect valid", {31'd0, reg_valid_o}, 32'd1);
    chk("R9 bar reset redirect addr", reg_addr_o, 32'h2180_0040);

    // R2: global off, even with region enabled
    cfg_wr(2'd0, 3'd0, 32'h7000_0001);
    ob_send(32'h6000_0054, 32'h1111_2222);
    chk("R2 no emit", {31'd0, ob_valid_o}, 32'd0);
    chk("R2 err set", {31'd0, err_o}, 32'd1);
    @(negedge clk);
    chk("R7 err held", {31'd0, err_o}, 32'd1);
    clear_err();
    chk("R7 err cleared", {31'd0, err_o}, 32'd0);

    // R10 program regions, region 5 disabled
    for (int r = 0; r < 8; r++) begin
      m_base[r] = 32'h4000_0000 + r * 32'h0130_0000;
      m_en[r]   = (r != 5);
      cfg_wr(2'd0, 3'(r), m_base[r] | {31'd0, m_en[r]});
    end
    cfg_wr(2'd1, 3'd0, 32'h1);

    // R1/R3 sweep
    for (int r = 0; r < 8; r++) begin
      for (int k = 0; k < 3; k++) begin
        logic [31:0] a, d;
        a = 32'h6000_0000 + (r << 20) + offs[k];
        d = 32'hD000_0000 + r * 16 + k;
        ob_send(a, d);
        if (m_en[r]) begin
          chk("R1 valid", {31'd0, ob_valid_o}, 32'd1);
          chk("R1 addr", ob_addr_o, m_base[r] + offs[k]);
          chk("R1 data", ob_data_o, d);
          chk("R3 err clear on good", {31'd0, err_o}, 32'd0);
        end else begin
          chk("R3 dropped", {31'd0, ob_valid_o}, 32'd0);
          chk("R3 err set", {31'd0, err_o}, 32'd1);
          clear_err();
        end
      end
    end

    // R8 outside window
    ob_send(32'h5FFF_FFFC, 32'h5);
    chk("R8 below", {31'd0, ob_valid_o}, 32'd0);
    ob_send(32'h6080_0000, 32'h6);
    chk("R8 above", {31'd0, ob_valid_o}, 32'd0);
    chk("R8 no err", {31'd0, err_o}, 32'd0);

    // R1 example, then R4 retarget same cycle
    cfg_wr(2'd0, 3'd0, 32'h7000_0001);
    ob_send(32'h6000_0054, 32'h0);
    chk("R1 example", ob_addr_o, 32'h7000_0054);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_idx = 3'd0; cfg_wdata = 32'h9000_0001;
    ob_valid = 1'b1; ob_addr = 32'h6000_0054; ob_data = 32'h77;
    @(negedge clk);
    cfg_we = 1'b0; ob_valid = 1'b0;
    chk("R4 old base in flight", ob_addr_o, 32'h7000_0054);
    ob_send(32'h6000_0054, 32'h78);
    chk("R4 new base", ob_addr_o, 32'h9000_0054);
    cfg_wr(2'd0, 3'd0, 32'h7000_0001);
    ob_send(32'h6000_0100, 32'h79);
    chk("R4 restored", ob_addr_o, 32'h7000_0100);

    // R7 clear and fault same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd3;
    ob_valid = 1'b1; ob_addr = 32'h6050_0000;
    @(negedge clk);
    cfg_we = 1'b0; ob_valid = 1'b0;
    chk("R7 set wins", {31'd0, err_o}, 32'd1);
    clear_err();
    chk("R7 cleared", {31'd0, err_o}, 32'd0);

    // R2 global off again
    cfg_wr(2'd1, 3'd0, 32'h0);
    ob_send(32'h6010_0000, 32'h1);
    chk("R2 gated", {31'd0, ob_valid_o}, 32'd0);
    chk("R2 err", {31'd0, err_o}, 32'd1);

    // R5/R6 inbound
    cfg_wr(2'd2, 3'd0, 32'h7000_0000);
    ib_send(32'h7000_0054, 32'hBEEF_0001);
    chk("R5 valid", {31'd0, reg_valid_o}, 32'd1);
    chk("R5 addr", reg_addr_o, 32'h2180_0054);
    chk("R5 data", reg_data_o, 32'hBEEF_0001);
    ib_send(32'h7000_3FFC, 32'hBEEF_0002);
    chk("R5 top edge", reg_addr_o, 32'h2180_3FFC);
    ib_send(32'h7000_4000, 32'hBEEF_0003);
    chk("R6 above valid", {31'd0, pass_valid_o}, 32'd1);
    chk("R6 above no redirect", {31'd0, reg_valid_o}, 32'd0);
    chk("R6 above addr", pass_addr_o, 32'h7000_4000);
    chk("R6 above data", pass_data_o, 32'hBEEF_0003);
    ib_send(32'h6FFF_FFFC, 32'hBEEF_0004);
    chk("R6 below addr", pass_addr_o, 32'h6FFF_FFFC);
    chk("R6 below valid", {31'd0, pass_valid_o}, 32'd1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule